// File: doc/BRIEF.md
# Toggle-Aware Compression Selector

This block sits just ahead of a link that moves data as a series of fixed-width flits over the same wires. For each transfer it is handed two versions of the payload: the plain form and a compressed form. Each comes with its own flit count. The link's energy follows the number of wires that change level from one flit to the next. For that reason, the block does not pick the compressed form just because it is shorter.

For each candidate, the block counts the wire transitions that candidate would cause. The count starts from the flit most recently driven onto the link and runs through every flit of the candidate. Each candidate then gets a cost equal to its flit count times a per-flit weight, plus its transition count. The compressed form goes out only if its cost is strictly lower.

The chosen flits leave one per cycle on a valid/ready stream. They carry a flag that tells the receiver which form it is getting, plus markers for the first and last flit. Counting and deciding take a fixed number of cycles. The block takes one transfer at a time and does not accept the next until the current one has fully left.

Top module: `toggle_aware_selector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The remembered previous link flit is all zeros, so the first transfer's transition count starts from a zero flit.
- R2: `in_ready` is 1 only when no transfer is held. A transfer is taken on a cycle with `in_valid` and `in_ready` both high, and `in_ready` stays 0 from that point until the last flit of that transfer has been handed off.
- R3: The transition count of a candidate with n flits is the number of differing bits between the previous link flit and the candidate's flit 0, plus the number of differing bits between flits i-1 and i for i = 1 to n-1. The previous link flit is the last flit actually accepted at the output.
- R4: The compressed form is chosen when `cmp_count`*`cfg_weight` + compressed transitions < `raw_count`*`cfg_weight` + raw transitions. On equal costs the raw form is chosen. The weight is sampled when the transfer is taken.
- R5: A `cmp_count` of 0 means no compressed form exists, and the raw form is sent.
- R6: The first output flit is presented with `out_valid` high exactly 3 clock edges after the edge on which the transfer was taken.
- R7: The chosen form's flits leave in order, flit k taken from bits [k*FLIT_W +: FLIT_W] of the chosen payload. Exactly count flits leave. `out_first` marks flit 0 and `out_last` marks flit count-1. After the last handshake, `out_valid` falls and `in_ready` rises.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_compressed`, `out_first` and `out_last` hold their values.
- R9: `out_compressed` is 1 when the compressed form is being sent and 0 for raw. It holds one value across all flits of a transfer.
- R10: Flit slots at or beyond a candidate's count affect neither the decision nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_weight | input | WEIGHT_W | Cost of one flit, in transition units |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Block can take a transfer |
| raw_data | input | MAX_FLITS*FLIT_W | Uncompressed payload, flit k in slot k |
| raw_count | input | CNT_W | Uncompressed flit count, 1 to MAX_FLITS |
| cmp_data | input | MAX_FLITS*FLIT_W | Compressed payload, flit k in slot k |
| cmp_count | input | CNT_W | Compressed flit count, 0 meaning absent |
| out_valid | output | 1 | Output flit present |
| out_ready | input | 1 | Downstream takes the flit |
| out_data | output | FLIT_W | Output flit |
| out_compressed | output | 1 | 1 when the compressed form is sent |
| out_first | output | 1 | Marks flit 0 of a transfer |
| out_last | output | 1 | Marks the final flit of a transfer |

## Verification
The hardest case to reach is a decision that hinges on the previous link flit. That flit is never visible at the inputs; it is whatever the prior transfer ended with. The stimulus table therefore runs as one chain of transfers. The bench keeps its own copy of each transfer's final output flit and feeds that copy into the next expected cost. A later directed test resets the block in the middle of a stream, then replays a transfer whose outcome differs depending on whether that history was cleared. Unused flit slots are filled with junk, and stalls are inserted, so that neither the junk nor backpressure can shift the outcome.

// File: rtl/toggle_aware_selector.sv
module toggle_aware_selector #(
  parameter int FLIT_W    = 128,
  parameter int MAX_FLITS = 4,
  parameter int WEIGHT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WEIGHT_W-1:0]         cfg_weight,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [MAX_FLITS*FLIT_W-1:0] raw_data,
  input  logic [$clog2(MAX_FLITS+1)-1:0] raw_count,
  input  logic [MAX_FLITS*FLIT_W-1:0] cmp_data,
  input  logic [$clog2(MAX_FLITS+1)-1:0] cmp_count,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [FLIT_W-1:0]           out_data,
  output logic                        out_compressed,
  output logic                        out_first,
  output logic                        out_last
);
  localparam int CNT_W  = $clog2(MAX_FLITS+1);
  localparam int IDX_W  = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1;
  localparam int BYTES  = FLIT_W / 8;
  localparam int PC_W   = $clog2(FLIT_W+1);
  localparam int TGL_W  = $clog2(MAX_FLITS*FLIT_W+1);
  localparam int COST_W = TGL_W + WEIGHT_W + CNT_W + 1;

  typedef enum logic [1:0] {IDLE, COUNT, DECIDE, SEND} state_t;

  function automatic logic [PC_W-1:0] popcnt(input logic [FLIT_W-1:0] v);
    logic [PC_W-1:0] acc [BYTES];
    for (int b = 0; b < BYTES; b++) begin
      acc[b] = '0;
      for (int j = 0; j < 8; j++) acc[b] = acc[b] + PC_W'(v[b*8+j]);
    end
    for (int s = 1; s < BYTES; s = s * 2)
      for (int i = 0; i + s < BYTES; i = i + 2*s)
        acc[i] = acc[i] + acc[i+s];
    return acc[0];
  endfunction

  state_t                        state;
  logic [MAX_FLITS*FLIT_W-1:0]   raw_q, cmp_q;
  logic [CNT_W-1:0]              raw_n_q, cmp_n_q, len_q;
  logic [WEIGHT_W-1:0]           w_q;
  logic [FLIT_W-1:0]             last_q;
  logic [PC_W-1:0]               raw_pc [MAX_FLITS];
  logic [PC_W-1:0]               cmp_pc [MAX_FLITS];
  logic [PC_W-1:0]               raw_pc_q [MAX_FLITS];
  logic [PC_W-1:0]               cmp_pc_q [MAX_FLITS];
  logic [TGL_W-1:0]              raw_t, cmp_t;
  logic [COST_W-1:0]             raw_cost, cmp_cost;
  logic                          use_cmp, sel_q;
  logic [IDX_W-1:0]              idx_q;

  for (genvar k = 0; k < MAX_FLITS; k++) begin : g_pair
    logic [FLIT_W-1:0] rprev, cprev;
    if (k == 0) begin : g_head
      assign rprev = last_q;
      assign cprev = last_q;
    end else begin : g_body
      assign rprev = raw_q[(k-1)*FLIT_W +: FLIT_W];
      assign cprev = cmp_q[(k-1)*FLIT_W +: FLIT_W];
    end
    assign raw_pc[k] = (CNT_W'(k) < raw_n_q) ? popcnt(rprev ^ raw_q[k*FLIT_W +: FLIT_W]) : '0;
    assign cmp_pc[k] = (CNT_W'(k) < cmp_n_q) ? popcnt(cprev ^ cmp_q[k*FLIT_W +: FLIT_W]) : '0;
  end

  always_comb begin
    raw_t = '0;
    cmp_t = '0;
    for (int k = 0; k < MAX_FLITS; k++) begin
      raw_t = raw_t + TGL_W'(raw_pc_q[k]);
      cmp_t = cmp_t + TGL_W'(cmp_pc_q[k]);
    end
  end

  assign raw_cost = COST_W'(raw_n_q) * COST_W'(w_q) + COST_W'(raw_t);
  assign cmp_cost = COST_W'(cmp_n_q) * COST_W'(w_q) + COST_W'(cmp_t);
  assign use_cmp  = (cmp_n_q != '0) && (cmp_cost < raw_cost);

  assign in_ready       = (state == IDLE);
  assign out_valid      = (state == SEND);
  assign out_data       = sel_q ? cmp_q[idx_q*FLIT_W +: FLIT_W] : raw_q[idx_q*FLIT_W +: FLIT_W];
  assign out_compressed = sel_q;
  assign out_first      = (idx_q == '0);
  assign out_last       = (CNT_W'(idx_q) + CNT_W'(1) == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      raw_q   <= '0;
      cmp_q   <= '0;
      raw_n_q <= '0;
      cmp_n_q <= '0;
      w_q     <= '0;
      last_q  <= '0;
      sel_q   <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      for (int k = 0; k < MAX_FLITS; k++) begin
        raw_pc_q[k] <= '0;
        cmp_pc_q[k] <= '0;
      end
    end else begin
      case (state)
        IDLE: if (in_valid) begin
          raw_q   <= raw_data;
          cmp_q   <= cmp_data;
          raw_n_q <= raw_count;
          cmp_n_q <= cmp_count;
          w_q     <= cfg_weight;
          state   <= COUNT;
        end
        COUNT: begin
          for (int k = 0; k < MAX_FLITS; k++) begin
            raw_pc_q[k] <= raw_pc[k];
            cmp_pc_q[k] <= cmp_pc[k];
          end
          state <= DECIDE;
        end
        DECIDE: begin
          sel_q <= use_cmp;
          len_q <= use_cmp ? cmp_n_q : raw_n_q;
          idx_q <= '0;
          state <= SEND;
        end
        SEND: if (out_ready) begin
          last_q <= out_data;
          if (out_last) begin
            idx_q <= '0;
            state <= IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/toggle_aware_selector_checker.sv
module toggle_aware_selector_checker #(
  parameter int FLIT_W    = 128,
  parameter int MAX_FLITS = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic [$clog2(MAX_FLITS+1)-1:0] cmp_count,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [FLIT_W-1:0]              out_data,
  input logic                           out_compressed,
  input logic                           out_first,
  input logic                           out_last
);
  assert_idle_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##3 (out_valid && out_first));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_compressed) && $stable(out_first) && $stable(out_last)));

  assert_end_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  assert_flag_constant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> (out_compressed == $past(out_compressed)));

  assert_absent_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cmp_count == '0) |-> ##3 !out_compressed);
endmodule

bind toggle_aware_selector toggle_aware_selector_checker #(
  .FLIT_W(FLIT_W), .MAX_FLITS(MAX_FLITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cmp_count(cmp_count), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_compressed(out_compressed),
  .out_first(out_first), .out_last(out_last)
);

// File: tb/toggle_aware_selector_tb.sv
module toggle_aware_selector_tb;
  localparam int FW = 128;
  localparam int MF = 4;
  localparam int WW = 8;

  typedef struct packed {
    logic [31:0] rp; logic [31:0] rs; logic [2:0] rn;
    logic [31:0] cp; logic [31:0] cs; logic [2:0] cn;
    logic [7:0]  w;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0, 3'd4, 32'hFFFF_FFFF, 32'h0, 3'd1, 8'd8},
    '{32'h0000_0000, 32'h1, 3'd4, 32'h0000_0000, 32'h0, 3'd1, 8'd8},
    '{32'h0F0F_0F0F, 32'h3, 3'd3, 32'h0F0F_0F0F, 32'h0, 3'd2, 8'd0},
    '{32'hAAAA_AAAA, 32'h0, 3'd2, 32'hAAAA_AAAA, 32'h0, 3'd0, 8'd50},
    '{32'h1234_5678, 32'h11, 3'd2, 32'h1234_5678, 32'h11, 3'd2, 8'd5},
    '{32'h5555_5555, 32'h0, 3'd1, 32'hAAAA_AAAA, 32'h0, 3'd1, 8'd3},
    '{32'h0000_00FF, 32'hFF00, 3'd4, 32'hFFFF_0000, 32'hFFFF_FFFF, 3'd1, 8'd255},
    '{32'hC3C3_C3C3, 32'h1, 3'd3, 32'h3C3C_3C3C, 32'h7, 3'd2, 8'd20},
    '{32'h0000_0001, 32'h2, 3'd4, 32'h8000_0000, 32'hF0F0_F0F0, 3'd3, 8'd1},
    '{32'hFFFF_FFFF, 32'h0, 3'd2, 32'h0000_0000, 32'h0, 3'd1, 8'd0}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [WW-1:0]        cfg_weight = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [MF*FW-1:0]     raw_data = '0, cmp_data = '0;
  logic [2:0]           raw_count = '0, cmp_count = '0;
  logic                 out_valid, out_ready = 1'b1;
  logic [FW-1:0]        out_data;
  logic                 out_compressed, out_first, out_last;

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] model_last = '0;

  always #10 clk = ~clk;

  toggle_aware_selector #(.FLIT_W(FW), .MAX_FLITS(MF), .WEIGHT_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_weight(cfg_weight),
    .in_valid(in_valid), .in_ready(in_ready),
    .raw_data(raw_data), .raw_count(raw_count),
    .cmp_data(cmp_data), .cmp_count(cmp_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_compressed(out_compressed), .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mkflit(input logic [31:0] p, input logic [31:0] s, input int i);
    logic [31:0] x;
    x = p ^ (s * 32'(i));
    return {4{x}};
  endfunction

  function automatic int tog(input logic [MF*FW-1:0] d, input int n, input logic [FW-1:0] prev);
    int t;
    logic [FW-1:0] p;
    t = 0;
    p = prev;
    for (int i = 0; i < n; i++) begin
      t += $countones(p ^ d[i*FW +: FW]);
      p = d[i*FW +: FW];
    end
    return t;
  endfunction

  task automatic run_vec(input vec_t v, input int vi, input bit stall);
    logic [MF*FW-1:0] rd, cd, chosen;
    int rt, ct, n, lat;
    bit exp_cmp;
    for (int i = 0; i < MF; i++) begin
      rd[i*FW +: FW] = (i < int'(v.rn)) ? mkflit(v.rp, v.rs, i) : {4{32'hDEAD_BEEF ^ 32'(i*7 + vi)}};
      cd[i*FW +: FW] = (i < int'(v.cn)) ? mkflit(v.cp, v.cs, i) : {4{32'hBAD0_F00D ^ 32'(i*13 + vi)}};
    end
    rt = tog(rd, int'(v.rn), model_last);
    ct = tog(cd, int'(v.cn), model_last);
    exp_cmp = (v.cn != 0) && (int'(v.cn)*int'(v.w) + ct < int'(v.rn)*int'(v.w) + rt);
    chosen = exp_cmp ? cd : rd;
    n = exp_cmp ? int'(v.cn) : int'(v.rn);

    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before accept", FW'(in_ready), FW'(1));
    raw_data = rd; cmp_data = cd; raw_count = v.rn; cmp_count = v.cn;
    cfg_weight = v.w; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    raw_data = '1; cmp_data = '1; cfg_weight = 8'hA5;
    lat = 1;
    while (!out_valid && lat < 12) begin
      chk(in_ready == 1'b0, "R2 busy", FW'(in_ready), FW'(0));
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R6 latency", FW'(lat), FW'(3));
    for (int f = 0; f < n; f++) begin
      if (stall && f == 1) begin
        logic [FW-1:0] held;
        held = out_data;
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid && out_data == held, "R8 stall hold", out_data, held);
        out_ready = 1'b1;
      end
      chk(out_valid == 1'b1, "R7 valid", FW'(out_valid), FW'(1));
      chk(out_data == chosen[f*FW +: FW], "R3 R4 R10 flit data", out_data, chosen[f*FW +: FW]);
      chk(out_compressed == exp_cmp, (v.cn == 0) ? "R5 absent form" : "R4 R9 flag",
          FW'(out_compressed), FW'(exp_cmp));
      chk(out_first == (f == 0), "R7 first", FW'(out_first), FW'(f == 0));
      chk(out_last == (f == n-1), "R7 last", FW'(out_last), FW'(f == n-1));
      @(negedge clk);
    end
    chk(!out_valid && in_ready, "R7 release", FW'({out_valid, in_ready}), FW'(2'b01));
    model_last = chosen[(n-1)*FW +: FW];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", FW'(out_valid), FW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset",
        FW'({in_ready, out_valid}), FW'(2'b10));

    for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi, vi[0]);

    // R1: reset in mid-stream clears the remembered link flit
    @(negedge clk);
    raw_data = {4{{4{32'hFFFF_FFFF}}}}; raw_count = 3'd4;
    cmp_data = '0; cmp_count = 3'd1; cfg_weight = 8'd1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-stream reset",
        FW'({out_valid, in_ready}), FW'(2'b01));
    rst_n = 1'b1;
    model_last = '0;
    // prev=0: raw all-ones 4 flits costs 4+128, compressed zero flit costs 1 -> compressed
    run_vec('{32'hFFFF_FFFF, 32'h0, 3'd4, 32'h0, 32'h0, 3'd1, 8'd1}, 20, 1'b0);
    // prev=0 now: compressed all-ones flit costs 1+128 vs raw zeros 2+0 -> raw
    run_vec('{32'h0, 32'h0, 3'd2, 32'hFFFF_FFFF, 32'h0, 3'd1, 8'd1}, 21, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule